// File: doc/BRIEF.md
# Programmable option setup controller

This block decodes byte-wide I/O reads and writes for the configuration space of a switchless expansion bus. It keeps two enable/setup registers, one for the system board and one for the adapters, plus a card-selected-feedback status register. It routes every access that falls in the eight-byte option window to exactly one setup target: the integrated video, the integrated I/O group, or one of the per-connector card-setup strobes.

The integrated I/O group has one configuration byte. This byte is reached through the option window while that group is in setup. It drives gated enables for the parallel port, the serial port and the diskette interface. It also drives the parallel base address, the serial base address and the serial IRQ, and the parallel bidirectional-mode flag.

Setup paths may be requested at the same time. When they are, a fixed priority picks one target and a conflict flag is raised. Register writes take effect at the next clock edge. Read data and setup strobes are combinational from the current access.

Top module: `pos_setup_ctrl`

## Requirements
- R1: After reset, address 0x94 reads 0xFF, address 0x96 reads 0x70, address 0x91 reads 0x00, the integrated I/O configuration byte is 0x00 and par_bidir is 1.
- R2: The setup target is chosen in this priority order:
  - video when bit 5 of the 0x94 register is 0;
  - otherwise the integrated I/O group when bit 7 of the 0x94 register is 0;
  - otherwise the card connector selected by bits 2..0 of the 0x96 register, when bit 3 of that register is 1, bit 7 is 0 and the selected value is below NUM_CONN;
  - otherwise no target.
  setup_conflict is 1 whenever two or more of these three requests are active.
- R3: A setup strobe (video_setup_stb, iogrp_setup_stb or card_setup_stb[n]) is high only while io_rd or io_wr is high with io_addr in 0x100..0x107. At most one strobe is high at any time.
- R4: A read of 0x96 returns the stored bits 7 and 3..0, with bits 6..4 forced to 1. chan_reset follows bit 7 of that register.
- R5: Offset 2 of the option window (0x102) holds the integrated I/O configuration byte. It can be written and read back only while the integrated I/O group is the setup target.
- R6: par_en = cfg[4] & cfg[0] & (cfg[6:5] != 2'b11). ser_en = cfg[2] & cfg[0]. fdc_en = cfg[1] & cfg[0].
- R7: cfg[6:5] sets par_base: 00 gives 0x3BC, 01 gives 0x378, 10 gives 0x278, and 11 gives 0x0000. cfg[3]=1 gives ser_base 0x3F8 with ser_irq 4. cfg[3]=0 gives ser_base 0x2F8 with ser_irq 3.
- R8: par_bidir is the inverse of cfg[7].
- R9: Bit 0 of 0x91 is set at a clock edge where card_fb or iodev_hit is high, and is cleared by a read of 0x91. If a set and a read happen in the same cycle, the set wins. Bits 7..1 of 0x91 read 0.
- R10: An option window access with no target ignores writes and reads 0xFF. With the integrated I/O group as target, offsets other than 2 read 0xFF. With video as target, reads return video_pos_rdata. With a card as target, reads return card_pos_rdata.
- R11: A read of any address not decoded above returns 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | ADDR_W | I/O address |
| io_wdata | input | 8 | Write data |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_rd | input | 1 | Read strobe, one cycle per read |
| io_rdata | output | 8 | Read data (combinational) |
| video_pos_rdata | input | 8 | Option data returned by the video in setup |
| card_pos_rdata | input | 8 | Option data returned by the selected card |
| card_fb | input | 1 | Card-selected feedback, active high |
| iodev_hit | input | 1 | An integrated I/O function was accessed |
| video_setup_stb | output | 1 | Setup strobe to the integrated video |
| iogrp_setup_stb | output | 1 | Setup strobe to the integrated I/O group |
| card_setup_stb | output | NUM_CONN | Per-connector card setup strobes |
| chan_reset | output | 1 | Channel reset to all connectors |
| setup_conflict | output | 1 | More than one setup path requested |
| par_en | output | 1 | Parallel port enable |
| ser_en | output | 1 | Serial port enable |
| fdc_en | output | 1 | Diskette interface enable |
| par_bidir | output | 1 | Parallel bidirectional mode allowed |
| par_base | output | 16 | Parallel port base address |
| ser_base | output | 16 | Serial port base address |
| ser_irq | output | 4 | Serial port interrupt level |

## Verification
The bench builds the block with its defaults: NUM_CONN of 4 and a 16-bit address. With these values it sweeps all 256 adapter-register values under each of the four combinations of the two system-board setup bits. That covers every target choice, every conflict case, every connector value above the connector count and every channel-reset case. It also sweeps all 256 integrated I/O configuration values, which covers every enable gate, base address and IRQ choice, including the reserved parallel select.

// File: rtl/pos_setup_pkg.sv
package pos_setup_pkg;

  localparam int unsigned SEL_W = 3;

  localparam logic [15:0] ADR_SB_SETUP = 16'h0094;
  localparam logic [15:0] ADR_AD_SETUP = 16'h0096;
  localparam logic [15:0] ADR_FEEDBACK = 16'h0091;
  localparam logic [15:0] ADR_OPT_WIN  = 16'h0100;
  localparam logic [2:0]  OFS_IOCFG    = 3'd2;

  typedef enum logic [1:0] {
    TGT_NONE  = 2'd0,
    TGT_VIDEO = 2'd1,
    TGT_IOGRP = 2'd2,
    TGT_CARD  = 2'd3
  } setup_tgt_e;

  // Parallel base from the two select bits; reserved code yields zero.
  function automatic logic [15:0] par_base_of(input logic [1:0] sel);
    case (sel)
      2'b00:   par_base_of = 16'h03BC;
      2'b01:   par_base_of = 16'h0378;
      2'b10:   par_base_of = 16'h0278;
      default: par_base_of = 16'h0000;
    endcase
  endfunction

  function automatic logic [15:0] ser_base_of(input logic primary);
    ser_base_of = primary ? 16'h03F8 : 16'h02F8;
  endfunction

  function automatic logic [3:0] ser_irq_of(input logic primary);
    ser_irq_of = primary ? 4'd4 : 4'd3;
  endfunction

  // Adapter register readback: middle three bits always read as ones.
  function automatic logic [7:0] ad_readback(input logic [7:0] ad);
    ad_readback = {ad[7], 3'b111, ad[3:0]};
  endfunction

endpackage

// File: rtl/pos_setup_regs.sv
module pos_setup_regs #(
  parameter logic [7:0] SB_RST = 8'hFF,
  parameter logic [7:0] AD_RST = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_sb,
  input  logic       wr_ad,
  input  logic [7:0] wdata,
  output logic [7:0] sb_q,
  output logic [7:0] ad_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sb_q <= SB_RST;
      ad_q <= AD_RST;
    end else begin
      if (wr_sb) sb_q <= wdata;
      if (wr_ad) ad_q <= wdata;
    end
  end

  // R4: adapter register only changes on its own write
  a_r4_ad_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ad |=> $stable(ad_q));

  // R2: system-board register only changes on its own write
  a_r2_sb_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_sb |=> $stable(sb_q));

endmodule

// File: rtl/pos_setup_steer.sv
module pos_setup_steer
  import pos_setup_pkg::*;
#(
  parameter int NUM_CONN = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               win_access,
  input  logic               video_setup_n,
  input  logic               iogrp_setup_n,
  input  logic               card_en,
  input  logic               chan_rst,
  input  logic [SEL_W-1:0]   card_sel,
  output setup_tgt_e         tgt,
  output logic               video_stb,
  output logic               iogrp_stb,
  output logic [NUM_CONN-1:0] card_stb,
  output logic               conflict
);

  logic video_req, iogrp_req, card_req;
  logic sel_in_range;

  assign sel_in_range = int'(card_sel) < NUM_CONN;
  assign video_req    = !video_setup_n;
  assign iogrp_req    = !iogrp_setup_n;
  assign card_req     = card_en && !chan_rst && sel_in_range;

  always_comb begin
    if (video_req)      tgt = TGT_VIDEO;
    else if (iogrp_req) tgt = TGT_IOGRP;
    else if (card_req)  tgt = TGT_CARD;
    else                tgt = TGT_NONE;
  end

  assign conflict  = (video_req && iogrp_req) || (video_req && card_req) ||
                     (iogrp_req && card_req);
  assign video_stb = win_access && (tgt == TGT_VIDEO);
  assign iogrp_stb = win_access && (tgt == TGT_IOGRP);

  for (genvar g = 0; g < NUM_CONN; g++) begin : g_card
    assign card_stb[g] = win_access && (tgt == TGT_CARD) && (card_sel == SEL_W'(g));
  end

  // R3: at most one strobe at a time
  a_r3_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({card_stb, iogrp_stb, video_stb}));

  // R3: strobes only inside an option window access
  a_r3_window: assert property (@(posedge clk) disable iff (!rst_n)
    ((|card_stb) || iogrp_stb || video_stb) |-> win_access);

  // R4: channel reset blocks every card strobe
  a_r4_reset_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    chan_rst |-> (card_stb == '0));

  // R2: video preempting a pending I/O group request is flagged
  a_r2_conflict_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (video_stb && !iogrp_setup_n) |-> conflict);

endmodule

// File: rtl/pos_iogrp_cfg.sv
module pos_iogrp_cfg
  import pos_setup_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr,
  input  logic [7:0]  wdata,
  output logic [7:0]  cfg_q,
  output logic        par_en,
  output logic        ser_en,
  output logic        fdc_en,
  output logic        par_bidir,
  output logic [15:0] par_base,
  output logic [15:0] ser_base,
  output logic [3:0]  ser_irq
);

  logic master;
  logic par_sel_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) cfg_q <= 8'h00;
    else if (wr) cfg_q <= wdata;
  end

  assign master     = cfg_q[0];
  assign par_sel_ok = cfg_q[6:5] != 2'b11;
  assign par_en     = master && cfg_q[4] && par_sel_ok;
  assign ser_en     = master && cfg_q[2];
  assign fdc_en     = master && cfg_q[1];
  assign par_bidir  = !cfg_q[7];
  assign par_base   = par_base_of(cfg_q[6:5]);
  assign ser_base   = ser_base_of(cfg_q[3]);
  assign ser_irq    = ser_irq_of(cfg_q[3]);

  // R6: no device enable without the master bit
  a_r6_master_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (par_en || ser_en || fdc_en) |-> cfg_q[0]);

  // R6: reserved parallel select never enables the port
  a_r6_par_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (par_base == 16'h0000) |-> !par_en);

  // R5: configuration byte holds without a write
  a_r5_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(cfg_q));

endmodule

// File: rtl/pos_feedback.sv
module pos_feedback (
  input  logic clk,
  input  logic rst_n,
  input  logic card_fb,
  input  logic iodev_hit,
  input  logic rd_clr,
  output logic fb_q
);

  logic set_ev;
  assign set_ev = card_fb || iodev_hit;

  always_ff @(posedge clk) begin
    if (!rst_n)      fb_q <= 1'b0;
    else if (set_ev) fb_q <= 1'b1;
    else if (rd_clr) fb_q <= 1'b0;
  end

  // R9: any feedback event latches the bit
  a_r9_set: assert property (@(posedge clk) disable iff (!rst_n)
    set_ev |=> fb_q);

  // R9: a read without a new event clears it
  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !set_ev) |=> !fb_q);

endmodule

// File: rtl/pos_setup_ctrl.sv
module pos_setup_ctrl
  import pos_setup_pkg::*;
#(
  parameter int NUM_CONN = 4,
  parameter int ADDR_W   = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   io_addr,
  input  logic [7:0]          io_wdata,
  input  logic                io_wr,
  input  logic                io_rd,
  output logic [7:0]          io_rdata,
  input  logic [7:0]          video_pos_rdata,
  input  logic [7:0]          card_pos_rdata,
  input  logic                card_fb,
  input  logic                iodev_hit,
  output logic                video_setup_stb,
  output logic                iogrp_setup_stb,
  output logic [NUM_CONN-1:0] card_setup_stb,
  output logic                chan_reset,
  output logic                setup_conflict,
  output logic                par_en,
  output logic                ser_en,
  output logic                fdc_en,
  output logic                par_bidir,
  output logic [15:0]         par_base,
  output logic [15:0]         ser_base,
  output logic [3:0]          ser_irq
);

  localparam logic [ADDR_W-1:0] A_SB   = ADDR_W'(ADR_SB_SETUP);
  localparam logic [ADDR_W-1:0] A_AD   = ADDR_W'(ADR_AD_SETUP);
  localparam logic [ADDR_W-1:0] A_FB   = ADDR_W'(ADR_FEEDBACK);
  localparam logic [ADDR_W-1:0] A_WIN  = ADDR_W'(ADR_OPT_WIN);
  localparam logic [ADDR_W-1:0] WIN_MK = ~ADDR_W'(7);

  // Decode events brought out for checking
  logic hit_sb, hit_ad, hit_fb, in_win, win_access;
  logic wr_sb, wr_ad, wr_cfg, rd_fb;
  logic [2:0] win_ofs;
  logic [7:0] sb_q, ad_q, cfg_q;
  logic fb_q;
  setup_tgt_e tgt;

  assign hit_sb     = io_addr == A_SB;
  assign hit_ad     = io_addr == A_AD;
  assign hit_fb     = io_addr == A_FB;
  assign in_win     = (io_addr & WIN_MK) == A_WIN;
  assign win_ofs    = io_addr[2:0];
  assign win_access = in_win && (io_rd || io_wr);
  assign wr_sb      = io_wr && hit_sb;
  assign wr_ad      = io_wr && hit_ad;
  assign rd_fb      = io_rd && hit_fb;
  assign wr_cfg     = io_wr && in_win && (win_ofs == OFS_IOCFG) && (tgt == TGT_IOGRP);

  pos_setup_regs #(.SB_RST(8'hFF), .AD_RST(8'h00)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_sb(wr_sb), .wr_ad(wr_ad),
    .wdata(io_wdata), .sb_q(sb_q), .ad_q(ad_q)
  );

  pos_setup_steer #(.NUM_CONN(NUM_CONN)) steer_i (
    .clk(clk), .rst_n(rst_n), .win_access(win_access),
    .video_setup_n(sb_q[5]), .iogrp_setup_n(sb_q[7]),
    .card_en(ad_q[3]), .chan_rst(ad_q[7]), .card_sel(ad_q[SEL_W-1:0]),
    .tgt(tgt), .video_stb(video_setup_stb), .iogrp_stb(iogrp_setup_stb),
    .card_stb(card_setup_stb), .conflict(setup_conflict)
  );

  pos_iogrp_cfg iogrp_i (
    .clk(clk), .rst_n(rst_n), .wr(wr_cfg), .wdata(io_wdata),
    .cfg_q(cfg_q), .par_en(par_en), .ser_en(ser_en), .fdc_en(fdc_en),
    .par_bidir(par_bidir), .par_base(par_base), .ser_base(ser_base),
    .ser_irq(ser_irq)
  );

  pos_feedback fb_i (
    .clk(clk), .rst_n(rst_n), .card_fb(card_fb), .iodev_hit(iodev_hit),
    .rd_clr(rd_fb), .fb_q(fb_q)
  );

  assign chan_reset = ad_q[7];

  always_comb begin
    io_rdata = 8'hFF;
    if (hit_sb)      io_rdata = sb_q;
    else if (hit_ad) io_rdata = ad_readback(ad_q);
    else if (hit_fb) io_rdata = {7'b0, fb_q};
    else if (in_win) begin
      case (tgt)
        TGT_VIDEO: io_rdata = video_pos_rdata;
        TGT_CARD:  io_rdata = card_pos_rdata;
        TGT_IOGRP: io_rdata = (win_ofs == OFS_IOCFG) ? cfg_q : 8'hFF;
        default:   io_rdata = 8'hFF;
      endcase
    end
  end

  // R10: window writes without the I/O group as target leave the byte alone
  a_r10_ignored_write: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && in_win && !iogrp_setup_stb) |=> $stable(cfg_q));

  // R5: the configuration byte only moves under an I/O group strobe
  a_r5_write_path: assert property (@(posedge clk) disable iff (!rst_n)
    !iogrp_setup_stb |=> $stable(cfg_q));

endmodule

// File: tb/pos_setup_ctrl_tb_top.sv
module pos_setup_ctrl_tb_top;

  localparam int NC = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] io_addr = '0;
  logic [7:0]  io_wdata = '0;
  logic        io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0]  io_rdata;
  logic [7:0]  video_pos_rdata = 8'hA5, card_pos_rdata = 8'h3C;
  logic        card_fb = 1'b0, iodev_hit = 1'b0;
  logic        video_setup_stb, iogrp_setup_stb, chan_reset, setup_conflict;
  logic [NC-1:0] card_setup_stb;
  logic        par_en, ser_en, fdc_en, par_bidir;
  logic [15:0] par_base, ser_base;
  logic [3:0]  ser_irq;

  int checks = 0, errors = 0;
  logic [7:0] rd_val;
  logic [5:0] stb_snap;

  always #4 clk = ~clk;

  pos_setup_ctrl #(.NUM_CONN(NC), .ADDR_W(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata),
    .video_pos_rdata(video_pos_rdata), .card_pos_rdata(card_pos_rdata),
    .card_fb(card_fb), .iodev_hit(iodev_hit),
    .video_setup_stb(video_setup_stb), .iogrp_setup_stb(iogrp_setup_stb),
    .card_setup_stb(card_setup_stb), .chan_reset(chan_reset),
    .setup_conflict(setup_conflict), .par_en(par_en), .ser_en(ser_en),
    .fdc_en(fdc_en), .par_bidir(par_bidir), .par_base(par_base),
    .ser_base(ser_base), .ser_irq(ser_irq)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0; io_addr = 16'h0000;
  endtask

  task automatic do_rd(input logic [15:0] a);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    #1;
    rd_val = io_rdata;
    stb_snap = {card_setup_stb, iogrp_setup_stb, video_setup_stb};
    @(negedge clk);
    io_rd = 1'b0; io_addr = 16'h0000;
  endtask

  // Expected strobe vector {card[3:0], iogrp, video} for a window access
  function automatic logic [5:0] exp_stb(input logic [7:0] sb, input logic [7:0] ad);
    logic [3:0] c;
    c = '0;
    if (sb[5] == 1'b0)      return 6'b000001;
    else if (sb[7] == 1'b0) return 6'b000010;
    else if (ad[3] && !ad[7] && ad[2:0] < 3'd4) begin
      c[ad[1:0]] = 1'b1;
      return {c, 2'b00};
    end
    return 6'b0;
  endfunction

  function automatic bit exp_conf(input logic [7:0] sb, input logic [7:0] ad);
    int n;
    n = 0;
    if (!sb[5]) n++;
    if (!sb[7]) n++;
    if (ad[3] && !ad[7] && ad[2:0] < 3'd4) n++;
    return n >= 2;
  endfunction

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] sbv [4];
    sbv[0] = 8'hFF; sbv[1] = 8'hDF; sbv[2] = 8'h7F; sbv[3] = 8'h5F;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    do_rd(16'h0094); chk(rd_val == 8'hFF, "R1 sb reset", rd_val, 8'hFF);
    do_rd(16'h0096); chk(rd_val == 8'h70, "R1 ad reset", rd_val, 8'h70);
    do_rd(16'h0091); chk(rd_val == 8'h00, "R1 fb reset", rd_val, 8'h00);
    chk(par_bidir == 1'b1, "R1 R8 bidir reset", par_bidir, 1);
    chk({par_en, ser_en, fdc_en} == 3'b000, "R1 enables reset", {par_en, ser_en, fdc_en}, 0);
    // R10 no target: window read 0xFF, write ignored
    do_rd(16'h0102); chk(rd_val == 8'hFF, "R10 no target read", rd_val, 8'hFF);
    chk(stb_snap == 6'b0, "R10 no target strobe", stb_snap, 0);
    do_wr(16'h0102, 8'h17);
    do_wr(16'h0094, 8'h7F);
    do_rd(16'h0102); chk(rd_val == 8'h00, "R10 write ignored", rd_val, 8'h00);
    // R11 unmapped
    do_rd(16'h0200); chk(rd_val == 8'hFF, "R11 unmapped", rd_val, 8'hFF);
    do_rd(16'h0095); chk(rd_val == 8'hFF, "R11 unmapped 95", rd_val, 8'hFF);

    // R2 R3 R4 R10 sweep: every adapter value under four system-board patterns
    for (int s = 0; s < 4; s++) begin
      do_wr(16'h0094, sbv[s]);
      for (int a = 0; a < 256; a++) begin
        logic [7:0] av;
        logic [15:0] wa;
        logic [5:0] es;
        logic [7:0] er;
        av = 8'(a);
        do_wr(16'h0096, av);
        do_rd(16'h0096);
        chk(rd_val == {av[7], 3'b111, av[3:0]}, "R4 readback", rd_val, {av[7], 3'b111, av[3:0]});
        chk(chan_reset == av[7], "R4 chan_reset", chan_reset, av[7]);
        chk(setup_conflict == exp_conf(sbv[s], av), "R2 conflict", setup_conflict, exp_conf(sbv[s], av));
        chk(stb_snap == 6'b0, "R3 no strobe outside window", stb_snap, 0);
        wa = 16'h0100 + 16'(a % 8);
        do_rd(wa);
        es = exp_stb(sbv[s], av);
        chk(stb_snap == es, "R2 R3 target strobe", stb_snap, es);
        if (es[0]) er = 8'hA5;
        else if (es[1]) er = 8'hFF; // offsets read 0xFF except 2 (cfg is 0x00)
        else if (es[5:2] != 0) er = 8'h3C;
        else er = 8'hFF;
        if (es[1] && wa[2:0] == 3'd2) er = 8'h00;
        chk(rd_val == er, "R10 window read", rd_val, er);
      end
    end
    // R3 no access, no strobe
    do_wr(16'h0094, 8'hDF);
    @(negedge clk); io_addr = 16'h0101; #1;
    chk(video_setup_stb == 1'b0, "R3 idle window", video_setup_stb, 0);
    io_addr = 16'h0108; io_rd = 1'b1; #1;
    chk(video_setup_stb == 1'b0, "R3 above window", video_setup_stb, 0);
    @(negedge clk); io_rd = 1'b0; io_addr = 0;

    // R5 R6 R7 R8 exhaustive configuration sweep
    do_wr(16'h0094, 8'h7F);
    do_wr(16'h0096, 8'h00);
    for (int v = 0; v < 256; v++) begin
      logic [7:0] c;
      logic [15:0] pb;
      c = 8'(v);
      do_wr(16'h0102, c);
      do_rd(16'h0102);
      chk(rd_val == c, "R5 cfg readback", rd_val, c);
      chk(par_en == (c[0] & c[4] & (c[6:5] != 2'b11)), "R6 par_en", par_en, c[0] & c[4]);
      chk(ser_en == (c[0] & c[2]), "R6 ser_en", ser_en, c[0] & c[2]);
      chk(fdc_en == (c[0] & c[1]), "R6 fdc_en", fdc_en, c[0] & c[1]);
      pb = (c[6:5] == 2'd0) ? 16'h03BC : (c[6:5] == 2'd1) ? 16'h0378 :
           (c[6:5] == 2'd2) ? 16'h0278 : 16'h0000;
      chk(par_base == pb, "R7 par_base", par_base, pb);
      chk(ser_base == (c[3] ? 16'h03F8 : 16'h02F8), "R7 ser_base", ser_base, c[3] ? 16'h03F8 : 16'h02F8);
      chk(ser_irq == (c[3] ? 4'd4 : 4'd3), "R7 ser_irq", ser_irq, c[3] ? 4 : 3);
      chk(par_bidir == !c[7], "R8 bidir", par_bidir, !c[7]);
      do_rd(16'h0105);
      chk(rd_val == 8'hFF, "R10 other offset", rd_val, 8'hFF);
    end
    // R5: leave setup, write must not land
    do_wr(16'h0102, 8'h15);
    do_wr(16'h0094, 8'hFF);
    do_wr(16'h0102, 8'h00);
    chk(par_en == 1'b1, "R5 write outside setup ignored", par_en, 1);

    // R9 feedback
    @(negedge clk); card_fb = 1'b1; @(negedge clk); card_fb = 1'b0;
    do_rd(16'h0091); chk(rd_val == 8'h01, "R9 card_fb set", rd_val, 8'h01);
    do_rd(16'h0091); chk(rd_val == 8'h00, "R9 read clears", rd_val, 8'h00);
    @(negedge clk); iodev_hit = 1'b1; @(negedge clk); iodev_hit = 1'b0;
    do_rd(16'h0091); chk(rd_val == 8'h01, "R9 iodev set", rd_val, 8'h01);
    @(negedge clk); io_addr = 16'h0091; io_rd = 1'b1; card_fb = 1'b1; #1;
    chk(io_rdata == 8'h00, "R9 read before same-cycle set", io_rdata, 8'h00);
    @(negedge clk); io_rd = 1'b0; card_fb = 1'b0; io_addr = 0;
    do_rd(16'h0091); chk(rd_val == 8'h01, "R9 set wins over clear", rd_val, 8'h01);
    do_rd(16'h0091); chk(rd_val == 8'h00, "R9 cleared", rd_val, 8'h00);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule